// File: doc/BRIEF.md
# Serial EEPROM Two-Wire Slave Controller

This block is the protocol side of a byte-addressed serial memory that answers as a slave on a two-wire bus. The raw clock and data lines are sampled in the system clock domain. The block finds start, repeated-start and stop conditions, shifts in the select byte and checks it against its strap pins. In a write it takes a two-byte address and collects data bytes. In a read it streams bytes out. It drives every acknowledge through an open-drain enable.

The block drives a synchronous byte-wide memory array. A read returns data on the cycle after the request. Accepted data bytes are held in a page buffer and are copied into the array only after a properly placed stop. The block then pulses a commit request to an external write-commit unit. While that unit reports busy, the block stays silent, so a master can poll for completion by sending the select byte until it gets an acknowledge. A write-lock input turns every data byte of a write into a NoAck and leaves the array unchanged. Reads do not depend on that input.

Top module: `seeprom_slave`

## Requirements
- R1: After reset, `sda_oe_o`, `mem_we_o` and `commit_o` are all low.
- R2: The select byte is received MSB first. The slave acknowledges it only when bits 7:4 equal 1010 and bits 3:1 equal `chip_sel_i`. Bit 0 selects the direction: 1 = read, 0 = write. On a mismatch the slave gives no acknowledge and ignores the bus until the next start.
- R3: In a write, two address bytes follow the select byte, high byte first, and each is acknowledged. Only the low `ADDR_W` bits of the 16-bit address are used. Each data byte is acknowledged and is written to the array after the stop.
- R4: Successive data bytes go to consecutive addresses inside the aligned `PAGE`-byte row and wrap at the row end. When the writes wrap, a later byte replaces an earlier byte at the same address.
- R5: If `wr_lock_i` is high at any cycle from the start until the end of the second address byte, the select and address bytes are still acknowledged. Every data byte gets NoAck, no array write is made, and there is no commit.
- R6: From a committing stop until `commit_busy_i` falls, the slave ignores the bus. It does not acknowledge even its own select byte.
- R7: A write is committed only when a stop follows a data-byte acknowledge with exactly one SCL high phase between them. A start or stop anywhere else discards the buffered bytes without a commit.
- R8: A read whose select byte comes without an address uses the internal counter. After a commit, the counter points one past the last written byte, wrapping within the row. After a read, it points one past the last byte read.
- R9: During a sequential read the counter increments over the full address range and wraps from the top address to 0.
- R10: When the master gives NoAck in the ninth bit of a read byte, the slave releases SDA and keeps it released until the next start.
- R11: Reads return the array contents whatever the level of `wr_lock_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Raw bus clock level |
| sda_i | input | 1 | Raw bus data level |
| sda_oe_o | output | 1 | Pull data line low when high |
| chip_sel_i | input | 3 | Strap value compared with select bits 3:1 |
| wr_lock_i | input | 1 | Write lock |
| mem_addr_o | output | ADDR_W | Array address |
| mem_rd_o | output | 1 | Array read request, data valid next cycle |
| mem_rdata_i | input | 8 | Array read data |
| mem_we_o | output | 1 | Array write strobe |
| mem_wdata_o | output | 8 | Array write data |
| commit_o | output | 1 | One-cycle request to the commit unit |
| commit_busy_i | input | 1 | Commit unit busy |

## Verification
The bench drives the bus as an open-drain master against a golden array. It targets six corner cases, and each has a clear failure signature.

- A write that wraps past the end of its row: a controller that carried the increment into the row bits would corrupt the next row.
- A sequential read across the top address: an off-by-one in the counter shows up as wrong or shifted bytes.
- Polling right after a stop: a controller that was not silent would acknowledge while the commit is still running.
- The lock raised only during the high address byte: a controller that sampled the lock too late would write the data anyway.
- Transfers cut short by a mid-byte start, a mid-byte stop, or a stop straight after the address: a wrong stop qualifier would commit partial or empty data.
- A master NoAck: a slave that kept transmitting would pull SDA low on the following clocks.

// File: rtl/seeprom_pkg.sv
package seeprom_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_SEL, ST_AHI, ST_ALO, ST_WDAT, ST_RDAT
  } slv_st_e;
  localparam logic [3:0] TYPE_CODE = 4'b1010;
endpackage

// File: rtl/seeprom_bus_sync.sv
module seeprom_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [1:0] raw, syn, prev;
  assign raw = {scl_i, sda_i};

  for (genvar g = 0; g < 2; g++) begin : g_line
    logic [STAGES-1:0] ff;
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni) ff <= '1;
      else         ff <= {ff[STAGES-2:0], raw[g]};
    assign syn[g] = ff[STAGES-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev <= 2'b11;
    else         prev <= syn;

  assign sda_o      = syn[0];
  assign scl_rise_o = syn[1] & ~prev[1];
  assign scl_fall_o = ~syn[1] & prev[1];
  // data edge while clock held high
  assign start_o    = syn[1] & prev[1] & prev[0] & ~syn[0];
  assign stop_o     = syn[1] & prev[1] & ~prev[0] & syn[0];
endmodule

// File: rtl/seeprom_page_buf.sv
module seeprom_page_buf #(
  parameter int PAGE = 32,
  localparam int IDX_W = $clog2(PAGE)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             wr_i,
  input  logic [IDX_W-1:0] widx_i,
  input  logic [7:0]       wdata_i,
  input  logic [IDX_W-1:0] ridx_i,
  output logic [7:0]       rdata_o,
  output logic             valid_o
);
  logic [7:0]      slot [PAGE];
  logic [PAGE-1:0] vld_q;

  always_ff @(posedge clk_i)
    if (wr_i) slot[widx_i] <= wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)    vld_q <= '0;
    else if (clr_i) vld_q <= '0;
    else if (wr_i)  vld_q[widx_i] <= 1'b1;

  assign rdata_o = slot[ridx_i];
  assign valid_o = vld_q[ridx_i];

  // R7
  buf_wr_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |-> !clr_i);
endmodule

// File: rtl/seeprom_slave.sv
module seeprom_slave
  import seeprom_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int PAGE   = 32,
  parameter int SYNC   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic [2:0]        chip_sel_i,
  input  logic              wr_lock_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_rd_o,
  input  logic [7:0]        mem_rdata_i,
  output logic              mem_we_o,
  output logic [7:0]        mem_wdata_o,
  output logic              commit_o,
  input  logic              commit_busy_i
);
  localparam int PIDX_W = $clog2(PAGE);
  localparam logic [PIDX_W-1:0] PIDX_MAX = PIDX_W'(PAGE - 1);

  logic sda_s, scl_rise, scl_fall, start_s, stop_s;

  seeprom_bus_sync #(.STAGES(SYNC)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_s), .stop_o(stop_s)
  );

  slv_st_e           st_q;
  logic [3:0]        cnt_q;
  logic [7:0]        sh_q, tx_q, ahi_q;
  logic              oe_q, rw_q, wp_q, mack_q, have_q;
  logic              fetch_q, rd_q, flush_q, commit_q;
  logic [ADDR_W-1:0] ptr_q;
  logic [PIDX_W-1:0] fidx_q;

  logic silent, commit_ok, sel_match, addr_phase, buf_wr, buf_clr, buf_vld;
  logic [7:0] buf_rdata;

  assign silent     = flush_q | commit_q | commit_busy_i;
  assign sel_match  = (sh_q[7:4] == TYPE_CODE) && (sh_q[3:1] == chip_sel_i);
  assign addr_phase = (st_q == ST_SEL) || (st_q == ST_AHI) || (st_q == ST_ALO);
  // stop one SCL high after a data-byte ack
  assign commit_ok  = (st_q == ST_WDAT) && (cnt_q == 4'd1) && have_q && !wp_q;
  assign buf_wr     = !silent && !start_s && !stop_s && (st_q == ST_WDAT)
                      && scl_fall && (cnt_q == 4'd8) && !wp_q;
  assign buf_clr    = (!silent && (start_s || (stop_s && !commit_ok)))
                      || (flush_q && fidx_q == PIDX_MAX);

  seeprom_page_buf #(.PAGE(PAGE)) u_buf (
    .clk_i, .rst_ni, .clr_i(buf_clr), .wr_i(buf_wr),
    .widx_i(ptr_q[PIDX_W-1:0]), .wdata_i(sh_q),
    .ridx_i(fidx_q), .rdata_o(buf_rdata), .valid_o(buf_vld)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; cnt_q <= '0; sh_q <= '0; tx_q <= 8'hFF; ahi_q <= '0;
      oe_q <= 1'b0; rw_q <= 1'b0; wp_q <= 1'b0; mack_q <= 1'b0; have_q <= 1'b0;
      fetch_q <= 1'b0; rd_q <= 1'b0; flush_q <= 1'b0; commit_q <= 1'b0;
      ptr_q <= '0; fidx_q <= '0;
    end else begin
      fetch_q  <= 1'b0;
      commit_q <= 1'b0;
      rd_q     <= fetch_q;
      if (rd_q) tx_q <= mem_rdata_i;
      if (flush_q) begin
        fidx_q <= fidx_q + 1'b1;
        if (fidx_q == PIDX_MAX) begin
          flush_q  <= 1'b0;
          commit_q <= 1'b1;
        end
      end
      if (silent) begin
        st_q <= ST_IDLE; oe_q <= 1'b0; cnt_q <= '0;
      end else if (start_s) begin
        st_q <= ST_SEL; oe_q <= 1'b0; cnt_q <= '0;
        wp_q <= wr_lock_i; have_q <= 1'b0;
      end else if (stop_s) begin
        st_q <= ST_IDLE; oe_q <= 1'b0; cnt_q <= '0; have_q <= 1'b0;
        if (commit_ok) begin
          flush_q <= 1'b1;
          fidx_q  <= '0;
        end
      end else if (st_q != ST_IDLE) begin
        if (addr_phase && wr_lock_i) wp_q <= 1'b1;
        if (scl_rise) begin
          cnt_q <= cnt_q + 4'd1;
          if (cnt_q < 4'd8) sh_q <= {sh_q[6:0], sda_s};
          else if (st_q == ST_RDAT) mack_q <= !sda_s;
        end else if (scl_fall) begin
          if (cnt_q == 4'd8) begin
            // ninth bit opens
            case (st_q)
              ST_SEL: begin
                if (sel_match) begin
                  oe_q    <= 1'b1;
                  rw_q    <= sh_q[0];
                  fetch_q <= sh_q[0];
                end else begin
                  st_q <= ST_IDLE;
                end
              end
              ST_AHI: begin oe_q <= 1'b1; ahi_q <= sh_q; end
              ST_ALO: begin oe_q <= 1'b1; ptr_q <= ADDR_W'({ahi_q, sh_q}); end
              ST_WDAT: begin
                oe_q <= !wp_q;
                if (!wp_q) begin
                  ptr_q  <= {ptr_q[ADDR_W-1:PIDX_W], ptr_q[PIDX_W-1:0] + 1'b1};
                  have_q <= 1'b1;
                end
              end
              ST_RDAT: begin oe_q <= 1'b0; ptr_q <= ptr_q + 1'b1; fetch_q <= 1'b1; end
              default: ;
            endcase
          end else if (cnt_q == 4'd9) begin
            // ninth bit closes
            cnt_q <= '0;
            case (st_q)
              ST_SEL: begin st_q <= rw_q ? ST_RDAT : ST_AHI; oe_q <= rw_q & !tx_q[7]; end
              ST_AHI: begin st_q <= ST_ALO; oe_q <= 1'b0; end
              ST_ALO: begin st_q <= ST_WDAT; oe_q <= 1'b0; end
              ST_RDAT: begin
                if (mack_q) oe_q <= !tx_q[7];
                else begin st_q <= ST_IDLE; oe_q <= 1'b0; end
              end
              default: oe_q <= 1'b0;
            endcase
          end else if (st_q == ST_RDAT && cnt_q != 4'd0) begin
            oe_q <= !tx_q[3'd7 - cnt_q[2:0]];
          end
        end
      end
    end
  end

  assign sda_oe_o    = oe_q;
  assign mem_rd_o    = fetch_q;
  assign mem_we_o    = flush_q & buf_vld;
  assign mem_wdata_o = buf_rdata;
  assign mem_addr_o  = flush_q ? {ptr_q[ADDR_W-1:PIDX_W], fidx_q} : ptr_q;
  assign commit_o    = commit_q;

  // R6
  busy_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_q || commit_busy_i) |-> !sda_oe_o);
  // R5
  lock_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> !wp_q);
  // R7
  commit_after_flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> $past(flush_q));
  // R6
  rd_we_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |-> !flush_q);
endmodule

// File: tb/sim_seeprom_slave.sv
module sim_seeprom_slave;
  localparam int AW = 9;
  localparam int MEMSZ = 1 << AW;
  localparam int PG = 32;
  localparam int Q = 4;
  localparam int BUSY = 200;
  localparam logic [2:0] CS = 3'b101;
  localparam logic [7:0] SEL_W = {4'b1010, CS, 1'b0};
  localparam logic [7:0] SEL_R = {4'b1010, CS, 1'b1};

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic m_scl = 1'b1, m_sda = 1'b1, lock = 1'b0;
  logic sda_oe, mem_rd, mem_we, commit, busy;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_rdata = 8'h00, mem_wdata;
  wire sda_line = m_sda & ~sda_oe;

  seeprom_slave #(.ADDR_W(AW), .PAGE(PG)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(m_scl), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .chip_sel_i(CS), .wr_lock_i(lock),
    .mem_addr_o(mem_addr), .mem_rd_o(mem_rd), .mem_rdata_i(mem_rdata),
    .mem_we_o(mem_we), .mem_wdata_o(mem_wdata), .commit_o(commit),
    .commit_busy_i(busy)
  );

  logic [7:0] arr [MEMSZ];
  logic [7:0] gold [MEMSZ];
  logic [7:0] wbuf [64];
  int busy_cnt = 0, n_commit = 0, n_chk = 0, n_fail = 0, gptr = 0;
  bit done = 0;

  always @(posedge clk) begin
    if (mem_we) arr[mem_addr] <= mem_wdata;
    if (mem_rd) mem_rdata <= arr[mem_addr];
    if (commit) begin busy_cnt <= BUSY; n_commit <= n_commit + 1; end
    else if (busy_cnt > 0) busy_cnt <= busy_cnt - 1;
  end
  assign busy = busy_cnt != 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n); repeat (n) @(negedge clk); endtask

  task automatic bus_start;
    m_sda = 1; tick(Q); m_scl = 1; tick(Q); m_sda = 0; tick(Q); m_scl = 0; tick(Q);
  endtask
  task automatic bus_stop;
    m_sda = 0; tick(Q); m_scl = 1; tick(Q); m_sda = 1; tick(Q);
  endtask
  task automatic send_bits(input logic [7:0] b, input int k);
    for (int i = 7; i > 7 - k; i--) begin
      m_sda = b[i]; tick(Q); m_scl = 1; tick(Q); m_scl = 0; tick(Q);
    end
  endtask
  task automatic send_byte(input logic [7:0] b, output bit ack);
    send_bits(b, 8);
    m_sda = 1; tick(Q); m_scl = 1; tick(Q); ack = !sda_line; m_scl = 0; tick(Q);
  endtask
  task automatic recv_byte(input bit mack, output logic [7:0] b);
    m_sda = 1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q); m_scl = 1; tick(Q); b[i] = sda_line; m_scl = 0; tick(Q);
    end
    m_sda = !mack; tick(Q); m_scl = 1; tick(Q); m_scl = 0; tick(Q); m_sda = 1;
  endtask
  task automatic wait_idle; tick(BUSY + PG + 60); endtask

  task automatic write_op(input int addr, input int n, input bit lock_hi,
                          output bit s_ack, output bit a_ack, output bit d_all, output bit d_none);
    bit a;
    bus_start;
    send_byte(SEL_W, s_ack);
    if (lock_hi) lock = 1;
    send_byte(addr[15:8], a); a_ack = a;
    if (lock_hi) lock = 0;
    send_byte(addr[7:0], a); a_ack &= a;
    d_all = 1; d_none = 1;
    for (int j = 0; j < n; j++) begin
      send_byte(wbuf[j], a); d_all &= a; d_none &= !a;
    end
    bus_stop;
  endtask

  task automatic gold_commit(input int addr, input int n);
    int row = (addr % MEMSZ) & ~(PG - 1), lo = addr % PG;
    for (int j = 0; j < n; j++) gold[row + ((lo + j) % PG)] = wbuf[j];
    gptr = row + ((lo + n) % PG);
  endtask

  task automatic read_rand(input int addr, input int n, input string tag);
    bit a, ok;
    logic [7:0] b;
    bus_start;
    send_byte(SEL_W, a); ok = a;
    send_byte(addr[15:8], a); ok &= a;
    send_byte(addr[7:0], a); ok &= a;
    bus_start;
    send_byte(SEL_R, a); ok &= a;
    chk(ok, {tag, " read setup acks"}, ok, 1);
    for (int k = 0; k < n; k++) begin
      recv_byte(k != n - 1, b);
      chk(b == gold[(addr + k) % MEMSZ], tag, b, gold[(addr + k) % MEMSZ]);
    end
    bus_stop;
    gptr = (addr + n) % MEMSZ;
  endtask

  task automatic read_cur(input int n, input string tag);
    bit a;
    logic [7:0] b;
    bus_start;
    send_byte(SEL_R, a);
    chk(a, {tag, " select ack"}, a, 1);
    for (int k = 0; k < n; k++) begin
      recv_byte(k != n - 1, b);
      chk(b == gold[(gptr + k) % MEMSZ], tag, b, gold[(gptr + k) % MEMSZ]);
    end
    bus_stop;
    gptr = (gptr + n) % MEMSZ;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got %0h expected %0h", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    bit s, a, da, dn;
    int c0, addr, n;
    logic [7:0] b;
    void'($urandom(32'd2024));
    for (int i = 0; i < MEMSZ; i++) begin arr[i] = 8'hFF; gold[i] = 8'hFF; end
    tick(5);
    // R1
    chk(sda_oe == 0 && mem_we == 0 && commit == 0, "R1 reset outputs",
        {sda_oe, mem_we, commit}, 0);
    rst_n = 1; tick(5);

    // R2 mismatched chip bits and type code
    bus_start; send_byte({4'b1010, 3'b010, 1'b0}, a); bus_stop;
    chk(!a, "R2 wrong chip", a, 0);
    bus_start; send_byte({4'b1110, CS, 1'b1}, a);
    recv_byte(0, b); bus_stop;
    chk(!a, "R2 wrong type", a, 0);
    chk(b == 8'hFF, "R2 silent after mismatch", b, 8'hFF);

    // R3 byte write, high address bits ignored
    wbuf[0] = 8'h5A;
    write_op(16'hFE13, 1, 0, s, a, da, dn);
    chk(s && a && da, "R3 write acks", {s, a, da}, 3'b111);
    gold_commit(16'h0013, 1);
    // R6 polling during commit
    bus_start; send_byte(SEL_W, a); bus_stop;
    chk(!a, "R6 poll while busy", a, 0);
    wait_idle;
    bus_start; send_byte(SEL_W, a); bus_stop;
    chk(a, "R6 poll after busy", a, 1);
    // the poll above left the counter unchanged
    read_cur(2, "R8 current read after commit");
    read_cur(1, "R8 current read after read");
    read_rand(16'h0013, 1, "R3 readback");

    // R4 row wrap
    for (int j = 0; j < 6; j++) wbuf[j] = 8'h10 + j;
    write_op(16'h003C, 6, 0, s, a, da, dn);
    gold_commit(16'h003C, 6);
    wait_idle;
    read_rand(16'h0020, PG + 2, "R4 row wrap");

    // R5 lock held, then lock only during high address byte
    c0 = n_commit;
    wbuf[0] = 8'h11; wbuf[1] = 8'h22;
    lock = 1;
    write_op(16'h0080, 2, 0, s, a, da, dn);
    lock = 0;
    chk(s && a, "R5 select and address acked", {s, a}, 2'b11);
    chk(dn, "R5 data NoAck", dn, 1);
    write_op(16'h0081, 2, 1, s, a, da, dn);
    chk(dn, "R5 data NoAck, lock in address", dn, 1);
    tick(PG + 20);
    chk(n_commit == c0, "R5 no commit", n_commit, c0);
    // R11
    lock = 1;
    read_rand(16'h0080, 3, "R11 read under lock");
    read_rand(16'h0013, 1, "R11 read under lock");
    lock = 0;

    // R7 aborts
    c0 = n_commit;
    wbuf[0] = 8'h77;
    bus_start; send_byte(SEL_W, a); send_byte(8'h00, a); send_byte(8'h90, a);
    send_byte(8'h77, a); send_bits(8'hC3, 4); bus_start; bus_stop;
    bus_start; send_byte(SEL_W, a); send_byte(8'h00, a); send_byte(8'h91, a);
    send_bits(8'h3C, 3); bus_stop;
    bus_start; send_byte(SEL_W, a); send_byte(8'h00, a); send_byte(8'h92, a); bus_stop;
    tick(PG + 20);
    chk(n_commit == c0, "R7 no commit on abort", n_commit, c0);
    read_rand(16'h0090, 3, "R7 memory unchanged");

    // R9 rollover at the top address
    for (int j = 0; j < 2; j++) wbuf[j] = 8'hA0 + j;
    write_op(MEMSZ - 2, 2, 0, s, a, da, dn);
    gold_commit(MEMSZ - 2, 2);
    wait_idle;
    wbuf[0] = 8'hC5;
    write_op(0, 1, 0, s, a, da, dn);
    gold_commit(0, 1);
    wait_idle;
    read_rand(MEMSZ - 2, 4, "R9 rollover");

    // R10 master NoAck
    bus_start; send_byte(SEL_R, a); recv_byte(0, b);
    for (int k = 0; k < 9; k++) begin
      m_sda = 1; tick(Q); m_scl = 1; tick(Q);
      chk(!sda_oe, "R10 released after NoAck", sda_oe, 0);
      m_scl = 0; tick(Q);
    end
    bus_stop;

    // R3 R4 random pages
    for (int it = 0; it < 6; it++) begin
      addr = $urandom % MEMSZ;
      n = 1 + ($urandom % 36);
      for (int j = 0; j < n; j++) wbuf[j] = 8'($urandom);
      write_op(addr, n, 0, s, a, da, dn);
      chk(s && a && da, "R3 random write acks", {s, a, da}, 3'b111);
      gold_commit(addr, n);
      wait_idle;
      read_rand(addr & ~(PG - 1), PG, "R4 random row");
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule